// File: doc/BRIEF.md
# Card Bus Mode Switch with Programmable Card Clock

This unit holds the operating mode of a card bus shared by up to four slots. Software writes one 64-bit switch word to start a switch. The word carries the target slot, the data bus width with a double-data-rate flag, the high-speed timing flag, a power class and two counts that set the card clock. One count is the length of the high phase and the other is the length of the low phase, both in system clock cycles. Software works out each count as the ceiling of the system frequency divided by twice the wanted card frequency. It keeps the card clock between 400 kHz, the identification minimum, and 52 MHz.

A switch keeps the busy output high for a fixed number of system clocks, set by a parameter. The card-side handshake is modelled as this fixed latency plus three error-injection inputs. When the switch completes, the unit records three error flags: power class, timing and bus width. If any flag is set, the unit leaves the active configuration untouched and raises the error interrupt. Mode fields take effect only through slot 0. A switch word that names another slot changes only the slot selection and keeps the mode last applied through slot 0. Software therefore writes the word first with slot 0 and then with the target slot. The card clock is regenerated from the active high and low counts. It is held low while either count is zero.

Top module: `bus_mode_switch`

## Requirements
- R1: After reset the read word is 0x0000_000A_0000_0000 (power class 10, all other fields zero). Busy, the error interrupt, the card clock and the active slot are all 0.
- R2: A write while idle sets busy on the next clock edge. Busy stays high for exactly LATENCY system clocks, and the switch completes on the edge that clears it.
- R3: A write while busy is ignored. The switch in progress completes with its own word.
- R4: Switch and read word layout: low count [15:0], high count [31:16], power class [35:32], width field [42:40] (code 0 = 1-bit, 1 = 4-bit, 2 = 8-bit, bit 42 = DDR), timing flag [48], error flags [59:57], slot [61:60]. A switch without errors to slot 0 makes every mode field of the word active, and the read word shows it.
- R5: A switch without errors to slot 1, 2 or 3 changes only the slot field and the active_slot output. The mode fields keep the values last applied through slot 0.
- R6: With both counts non-zero, card_clk is high for exactly the high count and low for exactly the low count of system clocks, and the pattern repeats.
- R7: While the active high count or low count is zero, card_clk stays low.
- R8: A slot-0 switch whose width field is invalid sets the width error flag (bit 59) and applies nothing. The field is invalid when it holds width code 3, or DDR (bit 42) together with 1-bit width.
- R9: An injection input held high at completion sets its flag: bit 57 for power, bit 58 for timing, bit 59 for width. Any set flag leaves the configuration and slot unchanged. The error interrupt is high exactly while some flag is set. The flags clear when the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Switch word write strobe |
| wr_data | input | 64 | Switch word |
| rd_data | output | 64 | Active configuration, slot and error flags |
| sw_busy | output | 1 | Switch in progress |
| sw_err_irq | output | 1 | Switch error interrupt (level) |
| inj_pwr_err | input | 1 | Model of a power class failure, sampled at completion |
| inj_timing_err | input | 1 | Model of a timing failure, sampled at completion |
| inj_width_err | input | 1 | Model of a bus width failure, sampled at completion |
| active_slot | output | 2 | Currently selected slot |
| card_clk | output | 1 | Generated card clock |

## Verification
A wrong latency counter shows as busy falling one or more cycles early or late. That is visible on the first switch, within LATENCY+1 cycles of the write. Corrupted pending or active state shows in the read word on the edge the switch completes. This includes a slot-nonzero switch leaking mode fields, or a failed switch still committing. A wrong phase counter shows within one card clock period as a high or low run of the wrong length. A divider that ignores a zero count shows as an edge on card_clk where the output must stay flat.

// File: rtl/bms_pkg.sv
package bms_pkg;

    localparam int CNT_W  = 16;
    localparam int PWR_W  = 4;
    localparam int WID_W  = 3;
    localparam int SLOT_W = 2;

    localparam int LO_LSB   = 0;
    localparam int HI_LSB   = 16;
    localparam int PWR_LSB  = 32;
    localparam int WID_LSB  = 40;
    localparam int HS_BIT   = 48;
    localparam int PERR_BIT = 57;
    localparam int TERR_BIT = 58;
    localparam int WERR_BIT = 59;
    localparam int SLOT_LSB = 60;

    localparam logic [PWR_W-1:0] PWR_RESET = PWR_W'(10);

    // error vector order: [0] power class, [1] timing, [2] bus width
    localparam int ERR_N = 3;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [WID_W-1:0]  width;
        logic              hs;
        logic [PWR_W-1:0]  pwr;
        logic [CNT_W-1:0]  hi;
        logic [CNT_W-1:0]  lo;
    } mode_t;

    localparam mode_t MODE_RESET = '{slot: '0, width: '0, hs: 1'b0,
                                     pwr: PWR_RESET, hi: '0, lo: '0};

    function automatic mode_t unpack_word(input logic [63:0] w);
        mode_t m;
        m.slot  = w[SLOT_LSB +: SLOT_W];
        m.width = w[WID_LSB  +: WID_W];
        m.hs    = w[HS_BIT];
        m.pwr   = w[PWR_LSB  +: PWR_W];
        m.hi    = w[HI_LSB   +: CNT_W];
        m.lo    = w[LO_LSB   +: CNT_W];
        return m;
    endfunction

    function automatic logic [63:0] pack_word(input mode_t m, input logic [ERR_N-1:0] e);
        logic [63:0] w;
        w = '0;
        w[SLOT_LSB +: SLOT_W] = m.slot;
        w[WID_LSB  +: WID_W]  = m.width;
        w[HS_BIT]             = m.hs;
        w[PWR_LSB  +: PWR_W]  = m.pwr;
        w[HI_LSB   +: CNT_W]  = m.hi;
        w[LO_LSB   +: CNT_W]  = m.lo;
        w[PERR_BIT]           = e[0];
        w[TERR_BIT]           = e[1];
        w[WERR_BIT]           = e[2];
        return w;
    endfunction

endpackage

// File: rtl/bms_sequencer.sv
module bms_sequencer #(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic busy,
    output logic accept,
    output logic done
);
    localparam int LW = (LATENCY < 2) ? 1 : $clog2(LATENCY);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] cnt;
    } seq_t;

    seq_t st_q, st_d;

    assign busy   = st_q.busy;
    assign accept = wr_en && !st_q.busy;
    assign done   = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LW'(LATENCY - 1);
        end else if (done) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bms_errchk.sv
module bms_errchk
    import bms_pkg::*;
(
    input  mode_t             mode,
    input  logic              inj_pwr,
    input  logic              inj_timing,
    input  logic              inj_width,
    output logic [ERR_N-1:0]  err
);
    logic code_bad;
    logic ddr_bad;
    logic slot_zero;

    always_comb begin
        slot_zero = (mode.slot == '0);
        code_bad  = (mode.width[1:0] == 2'b11);
        ddr_bad   = mode.width[2] && (mode.width[1:0] == 2'b00);
        err[0]    = inj_pwr;
        err[1]    = inj_timing;
        err[2]    = inj_width || (slot_zero && (code_bad || ddr_bad));
    end
endmodule

// File: rtl/bms_clkgen.sv
module bms_clkgen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    input  logic          restart,
    output logic          card_clk
);
    typedef struct packed {
        logic          ck;
        logic [CW-1:0] cnt;
    } gen_t;

    gen_t st_q, st_d;
    logic enable;

    assign enable   = (hi_cnt != '0) && (lo_cnt != '0);
    assign card_clk = st_q.ck;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.ck  = 1'b0;
            st_d.cnt = '0;
        end else if (restart) begin
            st_d.ck  = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.ck) begin
            if (st_q.cnt >= hi_cnt - 1'b1) begin
                st_d.ck  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (st_q.cnt >= lo_cnt - 1'b1) begin
                st_d.ck  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bus_mode_switch.sv
module bus_mode_switch
    import bms_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic        sw_busy,
    output logic        sw_err_irq,
    input  logic        inj_pwr_err,
    input  logic        inj_timing_err,
    input  logic        inj_width_err,
    output logic [1:0]  active_slot,
    output logic        card_clk
);
    typedef struct packed {
        mode_t            act;
        mode_t            pend;
        logic [ERR_N-1:0] err;
        logic             restart;
    } top_t;

    top_t st_q, st_d;
    logic accept, done;
    logic [ERR_N-1:0] chk_err;

    bms_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .busy   (sw_busy),
        .accept (accept),
        .done   (done)
    );

    bms_errchk u_err (
        .mode       (st_q.pend),
        .inj_pwr    (inj_pwr_err),
        .inj_timing (inj_timing_err),
        .inj_width  (inj_width_err),
        .err        (chk_err)
    );

    bms_clkgen #(.CW(CNT_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cnt   (st_q.act.hi),
        .lo_cnt   (st_q.act.lo),
        .restart  (st_q.restart),
        .card_clk (card_clk)
    );

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        if (accept) begin
            st_d.pend = unpack_word(wr_data);
            st_d.err  = '0;
        end
        if (done) begin
            st_d.err = chk_err;
            if (chk_err == '0) begin
                if (st_q.pend.slot == '0) begin
                    st_d.act = st_q.pend;
                end else begin
                    st_d.act.slot = st_q.pend.slot;
                end
                st_d.restart = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act     <= MODE_RESET;
            st_q.pend    <= MODE_RESET;
            st_q.err     <= '0;
            st_q.restart <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = pack_word(st_q.act, st_q.err);
    assign sw_err_irq  = |st_q.err;
    assign active_slot = st_q.act.slot;
endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
    parameter int LATENCY = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [63:0] rd_data,
    input logic        sw_busy,
    input logic        sw_err_irq,
    input logic        card_clk
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (sw_busy) run_q <= run_q + 1;
        else              run_q <= '0;
    end

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_busy) |-> $past(wr_en));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_busy) |-> (run_q == 32'(LATENCY)));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy |-> $stable({rd_data[61:60], rd_data[48:0]}));

    // R7
    clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data[31:16] == 16'd0 || rd_data[15:0] == 16'd0) &&
         ($past(rd_data[31:16]) == 16'd0 || $past(rd_data[15:0]) == 16'd0)) |-> !card_clk);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_err_irq) |-> $fell(sw_busy));

    // R8
    width_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_busy) && rd_data[59]) |-> $stable(rd_data[42:40]));
endmodule

bind bus_mode_switch bms_checker #(.LATENCY(LATENCY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .sw_busy    (sw_busy),
    .sw_err_irq (sw_err_irq),
    .card_clk   (card_clk)
);

// File: tb/bus_mode_switch_test.sv
`timescale 1ns/1ps
module bus_mode_switch_test;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        sw_busy, sw_err_irq, card_clk;
    logic        inj_pwr_err = 1'b0, inj_timing_err = 1'b0, inj_width_err = 1'b0;
    logic [1:0]  active_slot;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [63:0] exp_w;

    always #10 clk = ~clk;

    bus_mode_switch #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sw_busy(sw_busy), .sw_err_irq(sw_err_irq),
        .inj_pwr_err(inj_pwr_err), .inj_timing_err(inj_timing_err),
        .inj_width_err(inj_width_err), .active_slot(active_slot),
        .card_clk(card_clk)
    );

    function automatic logic [63:0] mk(input int slot, input int width, input int hs,
                                       input int pwr, input int hi, input int lo);
        logic [63:0] w;
        w = '0;
        w[61:60] = 2'(slot);
        w[42:40] = 3'(width);
        w[48]    = 1'(hs);
        w[35:32] = 4'(pwr);
        w[31:16] = 16'(hi);
        w[15:0]  = 16'(lo);
        return w;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [63:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic measure(output int hi_len, output int lo_len);
        logic prev;
        int guard;
        prev = card_clk;
        guard = 0;
        @(negedge clk);
        while (!(card_clk && !prev) && guard < 500) begin
            prev = card_clk; guard++; @(negedge clk);
        end
        hi_len = 0;
        while (card_clk && hi_len < 500) begin hi_len++; @(negedge clk); end
        lo_len = 0;
        while (!card_clk && lo_len < 500) begin lo_len++; @(negedge clk); end
    endtask

    task automatic t_reset();
        check("R1 read word", rd_data, 64'h0000_000A_0000_0000);
        check("R1 busy", {63'd0, sw_busy}, 64'd0);
        check("R1 irq", {63'd0, sw_err_irq}, 64'd0);
        check("R1 card_clk", {63'd0, card_clk}, 64'd0);
        check("R1 slot", {62'd0, active_slot}, 64'd0);
        exp_w = 64'h0000_000A_0000_0000;
    endtask

    task automatic t_busy_and_apply();
        logic [63:0] w;
        w = mk(0, 1, 1, 3, 3, 2);
        write_word(w);
        check("R2 busy after write", {63'd0, sw_busy}, 64'd1);
        repeat (LAT - 1) @(negedge clk);
        check("R2 busy last cycle", {63'd0, sw_busy}, 64'd1);
        check("R4 not yet applied", rd_data, exp_w);
        @(negedge clk);
        check("R2 busy cleared", {63'd0, sw_busy}, 64'd0);
        check("R4 slot0 apply", rd_data, w);
        exp_w = w;
    endtask

    task automatic t_clock();
        int h, l;
        measure(h, l);
        check("R6 high 3", 64'(h), 64'd3);
        check("R6 low 2", 64'(l), 64'd2);
        exp_w = mk(0, 6, 0, 5, 1, 4);
        write_word(exp_w);
        wait_done();
        check("R4 ddr 8-bit apply", rd_data, exp_w);
        measure(h, l);
        check("R6 high 1", 64'(h), 64'd1);
        check("R6 low 4", 64'(l), 64'd4);
    endtask

    task automatic t_ignore_busy();
        logic [63:0] wa, wb;
        wa = mk(0, 2, 1, 7, 5, 5);
        wb = mk(0, 1, 0, 2, 2, 2);
        write_word(wa);
        write_word(wb);
        wait_done();
        check("R3 second write ignored", rd_data, wa);
        check("R3 not busy afterwards", {63'd0, sw_busy}, 64'd0);
        exp_w = wa;
    endtask

    task automatic t_slot();
        logic [63:0] w;
        w = exp_w;
        write_word(mk(2, 0, 0, 1, 9, 9));
        wait_done();
        w[61:60] = 2'd2;
        check("R5 slot2 keeps mode", rd_data, w);
        check("R5 active slot 2", {62'd0, active_slot}, 64'd2);
        write_word(exp_w);
        wait_done();
        check("R5 back to slot0", rd_data, exp_w);
        check("R5 active slot 0", {62'd0, active_slot}, 64'd0);
    endtask

    task automatic t_width_err();
        write_word(mk(0, 4, 0, 1, 2, 2));
        wait_done();
        check("R8 ddr 1-bit rejected", rd_data, exp_w | (64'd1 << 59));
        check("R8 irq", {63'd0, sw_err_irq}, 64'd1);
        write_word(mk(0, 3, 0, 1, 2, 2));
        wait_done();
        check("R8 code 3 rejected", rd_data, exp_w | (64'd1 << 59));
    endtask

    task automatic t_inject();
        logic [63:0] w;
        w = mk(0, 1, 0, 4, 2, 3);
        inj_pwr_err = 1'b1;
        write_word(w);
        wait_done();
        check("R9 power flag", rd_data, exp_w | (64'd1 << 57));
        inj_pwr_err = 1'b0;
        inj_timing_err = 1'b1;
        write_word(w);
        wait_done();
        check("R9 timing flag", rd_data, exp_w | (64'd1 << 58));
        inj_timing_err = 1'b0;
        inj_width_err = 1'b1;
        write_word(mk(3, 1, 0, 4, 2, 3));
        wait_done();
        check("R9 width flag slot kept", rd_data, exp_w | (64'd1 << 59));
        check("R9 irq set", {63'd0, sw_err_irq}, 64'd1);
        inj_width_err = 1'b0;
        write_word(w);
        check("R9 flags cleared on accept", {63'd0, sw_err_irq}, 64'd0);
        wait_done();
        check("R9 clean switch applies", rd_data, w);
        exp_w = w;
    endtask

    task automatic t_clkoff();
        int highs;
        exp_w = mk(0, 1, 0, 4, 0, 4);
        write_word(exp_w);
        wait_done();
        check("R7 read word", rd_data, exp_w);
        highs = 0;
        repeat (60) begin
            @(negedge clk);
            if (card_clk) highs++;
        end
        check("R7 clock held low", 64'(highs), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_and_apply();
        t_clock();
        t_ignore_busy();
        t_slot();
        t_width_err();
        t_inject();
        t_clkoff();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule